// File: doc/BRIEF.md
# SD Host Command Issue and Response Capture

This block is the command path of a memory-mapped SD host. Software programs a 32-bit argument and then writes a 16-bit command word through a small register port. If the start bit is set in that write, the block hands the command to the card side in one parallel handshake. It sends a single-cycle issue strobe with the 6-bit command index, the argument and the two data-direction flags. It then waits for the card's answer: a response strobe with a byte length and up to 128 response bits.

When the answer arrives, the block checks its length against the type of response that was requested. A good response goes into four 32-bit response words. A bad one sets a sticky fail bit in the command word and a sticky timeout flag in the status register. A successful busy-wait command can raise a busy interrupt. The start bit stays set for as long as a command is outstanding, so software polls it to learn when the command has completed.

The controller is a three-state machine. IDLE takes the transition *launch* to ISSUE when software writes the command word with the start bit set. ISSUE takes the transition *strobe* to WAIT after driving the issue strobe for one cycle. WAIT stays in WAIT while no response arrives, and takes the transition *complete* back to IDLE in the cycle it accepts the response.

Top module: `sdcmd_host`

## Requirements
- R1: After reset, every register reads zero (command word, argument, status, configuration and the four response words). The interrupt output and the issue strobe are low.
- R2: Register addresses are: 0 command word, 1 argument, 2 status, 3 configuration, 4 to 7 response words 0 to 3. Writing the command word with bit 15 set while the block is idle raises `card_cmd_valid` for exactly one cycle, in the cycle after the write. During that cycle the strobe carries `card_cmd_index` = command bits 5:0, `card_cmd_arg` = the argument register, `card_cmd_rd` = bit 6 and `card_cmd_wr` = bit 7.
- R3: Command bit 15 reads 1 from the start write until a response is accepted, and reads 0 from the cycle after that. While a command is outstanding, writes to the command word and to the argument are ignored.
- R4: When a response is expected (bit 10 clear) and the length is 4 bytes with bit 9 clear, response word 0 gets `card_rsp_data[127:96]`: byte 0 of the response, taken from bits 127:120, is the most significant byte. Response words 1 to 3 are cleared.
- R5: A 16-byte response is stored word-reversed: word 0 = `card_rsp_data[31:0]` (bytes 12 to 15), word 1 = `[63:32]`, word 2 = `[95:64]`, word 3 = `[127:96]`. Within each word the lower-numbered byte is the more significant one.
- R6: With command bit 10 set (no response expected), any response length completes the command without a failure. The response words are left unchanged.
- R7: When a response is expected, a length of 0 bytes, a length of 4 bytes with bit 9 set, or any length other than 4 or 16 counts as a failure. A failure sets command bit 14 and status bit 6 and leaves the response words unchanged.
- R8: Command bit 14 stays set until the next accepted write of the command word, and software cannot set it by writing. Status bit 6 stays set until software writes the status register with bit 6 set (write-1-to-clear).
- R9: A command with bit 11 set that completes without failure sets status bit 10, provided configuration bit 10 is 1. Status bit 10 is cleared by writing 1 to it. The `irq` output is the OR of status bits 10, 9 and 8.
- R10: Writing the command word with bit 15 clear stores it (it reads back) but issues nothing.
- R11: A 16-byte answer to a command that asked for a short response (bit 9 clear) is accepted and stored in the R5 layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt, OR of status bits 10:8 |
| card_cmd_valid | output | 1 | One-cycle command issue strobe to the card side |
| card_cmd_index | output | 6 | Command index |
| card_cmd_arg | output | 32 | Command argument |
| card_cmd_rd | output | 1 | Command is a read-data command |
| card_cmd_wr | output | 1 | Command is a write-data command |
| card_rsp_valid | input | 1 | Response strobe from the card side |
| card_rsp_len | input | 5 | Response length in bytes |
| card_rsp_data | input | 128 | Response bytes, byte 0 in bits 127:120 |

## Verification
The response path is driven with a 16-byte answer before a 4-byte one, each with distinct word patterns. This shows whether the words are placed in reversed order and whether the short capture clears the upper words left over from the long one. The failure cases (empty answer, short answer to a long request, odd length) are interleaved with good responses. This separates a failure that is detected and kept sticky from one that corrupts stored words or clears itself. Commands and argument writes issued while a command is outstanding show whether the lock-out holds. The busy-wait command is run with the interrupt enable both on and off, and with a failing answer, to tell the enable gating apart from the success gating.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } sdc_state_e;

    // command word bit positions
    localparam int CB_INDEX_W = 6;
    localparam int CB_RDDAT   = 6;
    localparam int CB_WRDAT   = 7;
    localparam int CB_LONG    = 9;
    localparam int CB_NORSP   = 10;
    localparam int CB_BUSYW   = 11;
    localparam int CB_FAIL    = 14;
    localparam int CB_START   = 15;
    localparam int CMD_W      = 16;

    // status / configuration bit positions
    localparam int SB_TIMEOUT = 6;
    localparam int SB_IRQ_LO  = 8;
    localparam int SB_BUSYIRQ = 10;
    localparam int STAT_W     = 11;
    localparam int CFG_BUSYEN = 10;
    localparam int CFG_W      = 11;

    // register word addresses
    localparam logic [2:0] RA_CMD  = 3'd0;
    localparam logic [2:0] RA_ARG  = 3'd1;
    localparam logic [2:0] RA_STAT = 3'd2;
    localparam logic [2:0] RA_CFG  = 3'd3;
    localparam logic [2:0] RA_RSP0 = 3'd4;

endpackage

// File: rtl/sdc_cmd_fsm.sv
module sdc_cmd_fsm
    import sdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic       rsp_valid,
    output sdc_state_e state,
    output logic       cmd_valid,
    output logic       busy,
    output logic       done
);

    sdc_state_e state_q;
    sdc_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cmd_valid = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (launch) begin
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                cmd_valid = 1'b1;
                state_d   = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    done    = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/sdc_rsp_unpack.sv
module sdc_rsp_unpack #(
    parameter int WORD_W    = 32,
    parameter int RSP_WORDS = 4,
    parameter int LEN_W     = 5
) (
    input  logic [LEN_W-1:0]                   rsp_len,
    input  logic [WORD_W*RSP_WORDS-1:0]        rsp_data,
    input  logic                               expect_rsp,
    input  logic                               want_long,
    output logic                               fail,
    output logic [RSP_WORDS-1:0][WORD_W-1:0]   words
);

    localparam int RSP_W       = WORD_W * RSP_WORDS;
    localparam int SHORT_BYTES = WORD_W / 8;
    localparam int LONG_BYTES  = RSP_W / 8;

    logic is_short;
    logic is_long;

    assign is_short = (rsp_len == LEN_W'(SHORT_BYTES));
    assign is_long  = (rsp_len == LEN_W'(LONG_BYTES));
    assign fail     = expect_rsp && !(is_long || (is_short && !want_long));

    for (genvar k = 0; k < RSP_WORDS; k++) begin : g_word
        if (k == 0) begin : g_first
            assign words[k] = is_long ? rsp_data[k*WORD_W +: WORD_W]
                                      : rsp_data[RSP_W-1 -: WORD_W];
        end else begin : g_rest
            assign words[k] = is_long ? rsp_data[k*WORD_W +: WORD_W]
                                      : '0;
        end
    end

endmodule

// File: rtl/sdc_csr.sv
module sdc_csr
    import sdc_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int RSP_WORDS = 4,
    parameter int ADDR_W    = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [WORD_W-1:0]                wdata,
    output logic [WORD_W-1:0]                rdata,
    input  logic                             busy,
    input  logic                             done,
    input  logic                             fail,
    input  logic [RSP_WORDS-1:0][WORD_W-1:0] words,
    output logic                             launch,
    output logic [CMD_W-1:0]                 cmd_q,
    output logic [WORD_W-1:0]                arg_q,
    output logic [STAT_W-1:0]                status_q,
    output logic [CFG_W-1:0]                 cfg_q
);

    localparam logic [STAT_W-1:0] W1C_MASK =
        STAT_W'((1 << SB_TIMEOUT) | (1 << SB_BUSYIRQ));

    logic [RSP_WORDS-1:0][WORD_W-1:0] rsp_q;
    logic [STAT_W-1:0]                status_d;
    logic                             wr_cmd;
    logic                             wr_arg;
    logic                             expect_rsp;
    logic                             busy_hit;

    assign wr_cmd     = wr_en && (addr == ADDR_W'(RA_CMD)) && !busy;
    assign wr_arg     = wr_en && (addr == ADDR_W'(RA_ARG)) && !busy;
    assign launch     = wr_cmd && wdata[CB_START];
    assign expect_rsp = !cmd_q[CB_NORSP];
    assign busy_hit   = done && !fail && cmd_q[CB_BUSYW] && cfg_q[CFG_BUSYEN];

    always_comb begin
        status_d = status_q;
        if (wr_en && (addr == ADDR_W'(RA_STAT))) begin
            status_d = status_q & ~(wdata[STAT_W-1:0] & W1C_MASK);
        end
        if (done && fail) begin
            status_d[SB_TIMEOUT] = 1'b1;
        end
        if (busy_hit) begin
            status_d[SB_BUSYIRQ] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            arg_q    <= '0;
            status_q <= '0;
            cfg_q    <= '0;
            rsp_q    <= '0;
        end else begin
            status_q <= status_d;
            if (wr_cmd) begin
                cmd_q <= {wdata[CB_START], 1'b0, wdata[CB_FAIL-1:0]};
            end
            if (wr_arg) begin
                arg_q <= wdata;
            end
            if (wr_en && (addr == ADDR_W'(RA_CFG))) begin
                cfg_q <= wdata[CFG_W-1:0];
            end
            if (done) begin
                cmd_q[CB_START] <= 1'b0;
                if (fail) begin
                    cmd_q[CB_FAIL] <= 1'b1;
                end else if (expect_rsp) begin
                    rsp_q <= words;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr >= ADDR_W'(RA_RSP0)) begin
            rdata = rsp_q[addr - ADDR_W'(RA_RSP0)];
        end else begin
            unique case (addr)
                ADDR_W'(RA_CMD):  rdata = WORD_W'(cmd_q);
                ADDR_W'(RA_ARG):  rdata = arg_q;
                ADDR_W'(RA_STAT): rdata = WORD_W'(status_q);
                ADDR_W'(RA_CFG):  rdata = WORD_W'(cfg_q);
                default:          rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_host.sv
module sdcmd_host
    import sdc_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int RSP_WORDS = 4,
    parameter int ADDR_W    = 3,
    parameter int LEN_W     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [WORD_W-1:0]           reg_wdata,
    output logic [WORD_W-1:0]           reg_rdata,
    output logic                        irq,
    output logic                        card_cmd_valid,
    output logic [CB_INDEX_W-1:0]       card_cmd_index,
    output logic [WORD_W-1:0]           card_cmd_arg,
    output logic                        card_cmd_rd,
    output logic                        card_cmd_wr,
    input  logic                        card_rsp_valid,
    input  logic [LEN_W-1:0]            card_rsp_len,
    input  logic [WORD_W*RSP_WORDS-1:0] card_rsp_data
);

    sdc_state_e                       state;
    logic                             launch;
    logic                             busy;
    logic                             done;
    logic                             fail;
    logic [RSP_WORDS-1:0][WORD_W-1:0] words;
    logic [CMD_W-1:0]                 cmd_q;
    logic [WORD_W-1:0]                arg_q;
    logic [STAT_W-1:0]                status_q;
    logic [CFG_W-1:0]                 cfg_q;

    sdc_cmd_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .rsp_valid (card_rsp_valid),
        .state     (state),
        .cmd_valid (card_cmd_valid),
        .busy      (busy),
        .done      (done)
    );

    sdc_rsp_unpack #(
        .WORD_W    (WORD_W),
        .RSP_WORDS (RSP_WORDS),
        .LEN_W     (LEN_W)
    ) i_unpack (
        .rsp_len    (card_rsp_len),
        .rsp_data   (card_rsp_data),
        .expect_rsp (!cmd_q[CB_NORSP]),
        .want_long  (cmd_q[CB_LONG]),
        .fail       (fail),
        .words      (words)
    );

    sdc_csr #(
        .WORD_W    (WORD_W),
        .RSP_WORDS (RSP_WORDS),
        .ADDR_W    (ADDR_W)
    ) i_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .busy     (busy),
        .done     (done),
        .fail     (fail),
        .words    (words),
        .launch   (launch),
        .cmd_q    (cmd_q),
        .arg_q    (arg_q),
        .status_q (status_q),
        .cfg_q    (cfg_q)
    );

    assign card_cmd_index = cmd_q[CB_INDEX_W-1:0];
    assign card_cmd_arg   = arg_q;
    assign card_cmd_rd    = cmd_q[CB_RDDAT];
    assign card_cmd_wr    = cmd_q[CB_WRDAT];
    assign irq            = |status_q[SB_BUSYIRQ:SB_IRQ_LO];

endmodule

// File: rtl/sdcmd_host_checker.sv
module sdcmd_host_checker
    import sdc_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  card_cmd_valid,
    input logic                  card_rsp_valid,
    input logic [CB_INDEX_W-1:0] card_cmd_index,
    input logic                  irq,
    input logic [CMD_W-1:0]      cmd_q,
    input logic [STAT_W-1:0]     status_q,
    input sdc_state_e            state
);

    logic in_wait;
    assign in_wait = (state == ST_WAIT);

    // R2: the issue strobe lasts a single cycle
    p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        card_cmd_valid |=> !card_cmd_valid);

    // R3: the command index holds while a command is outstanding
    p_index_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !(in_wait && card_rsp_valid)) |=> $stable(card_cmd_index));

    // R3: the start bit drops once a response is accepted
    p_start_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && card_rsp_valid) |=> !cmd_q[CB_START]);

    // R7: a failure always comes with the timeout flag
    p_fail_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_q[CB_FAIL]) |-> status_q[SB_TIMEOUT]);

    // R9: the interrupt rises only on a completed command
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(in_wait && card_rsp_valid));

endmodule

bind sdcmd_host sdcmd_host_checker i_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .card_cmd_valid (card_cmd_valid),
    .card_rsp_valid (card_rsp_valid),
    .card_cmd_index (card_cmd_index),
    .irq            (irq),
    .cmd_q          (cmd_q),
    .status_q       (status_q),
    .state          (state)
);

// File: tb/test_sdcmd_host.sv
`timescale 1ns/1ps
module test_sdcmd_host;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq;
    logic         card_cmd_valid;
    logic [5:0]   card_cmd_index;
    logic [31:0]  card_cmd_arg;
    logic         card_cmd_rd;
    logic         card_cmd_wr;
    logic         card_rsp_valid = 1'b0;
    logic [4:0]   card_rsp_len = '0;
    logic [127:0] card_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    localparam logic [127:0] LONG_DATA =
        128'h3333_3333_2222_2222_1111_1111_0000_0000 ^
        128'hC0DE_0003_BEEF_0002_CAFE_0001_F00D_0000;

    always #5 clk = ~clk;

    sdcmd_host i_sdcmd_host (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr         (reg_wr),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .irq            (irq),
        .card_cmd_valid (card_cmd_valid),
        .card_cmd_index (card_cmd_index),
        .card_cmd_arg   (card_cmd_arg),
        .card_cmd_rd    (card_cmd_rd),
        .card_cmd_wr    (card_cmd_wr),
        .card_rsp_valid (card_rsp_valid),
        .card_rsp_len   (card_rsp_len),
        .card_rsp_data  (card_rsp_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // drive the card answer for one cycle; called right after the strobe check
    task automatic answer(input logic [4:0] len, input logic [127:0] data);
        @(negedge clk);
        card_rsp_valid = 1'b1; card_rsp_len = len; card_rsp_data = data;
        @(negedge clk);
        card_rsp_valid = 1'b0; card_rsp_data = '0; card_rsp_len = '0;
    endtask

    task automatic run_cmd(input logic [15:0] word, input logic [31:0] arg,
                           input logic [4:0] len, input logic [127:0] data);
        wr(3'd1, arg);
        wr(3'd0, {16'h0, word});
        check("R2 strobe", {31'h0, card_cmd_valid}, 32'h1);
        check("R2 index", {26'h0, card_cmd_index}, {26'h0, word[5:0]});
        check("R2 arg", card_cmd_arg, arg);
        check("R2 dir", {30'h0, card_cmd_wr, card_cmd_rd}, {30'h0, word[7:6]});
        answer(len, data);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) check_reg("R1 reg", 3'(a), 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 strobe", {31'h0, card_cmd_valid}, 32'h0);
    endtask

    task automatic t_store_only();
        wr(3'd0, 32'h0000_0011);
        check("R10 no strobe", {31'h0, card_cmd_valid}, 32'h0);
        @(negedge clk);
        check("R10 no strobe later", {31'h0, card_cmd_valid}, 32'h0);
        check_reg("R10 readback", 3'd0, 32'h0000_0011);
    endtask

    task automatic t_long();
        run_cmd(16'h8202, 32'h1234_5678, 5'd16, LONG_DATA);
        check_reg("R3 start clear", 3'd0, 32'h0000_0202);
        for (int k = 0; k < 4; k++)
            check_reg("R5 word", 3'(4 + k), LONG_DATA[k*32 +: 32]);
    endtask

    task automatic t_short();
        run_cmd(16'h8051, 32'hA5A5_1234, 5'd4, {32'hDEAD_BEEF, 96'h1});
        check_reg("R4 word0", 3'd4, 32'hDEAD_BEEF);
        for (int k = 1; k < 4; k++) check_reg("R4 cleared", 3'(4 + k), 32'h0);
        check_reg("R4 no fail", 3'd0, 32'h0000_0051);
    endtask

    task automatic t_outstanding();
        wr(3'd1, 32'h0000_00AA);
        wr(3'd0, 32'h0000_8085);
        check("R2 strobe", {31'h0, card_cmd_valid}, 32'h1);
        check("R2 wr flag", {31'h0, card_cmd_wr}, 32'h1);
        wr(3'd0, 32'h0000_803F);
        wr(3'd1, 32'h0000_0055);
        check("R3 no second strobe", {31'h0, card_cmd_valid}, 32'h0);
        check("R3 index held", {26'h0, card_cmd_index}, 32'h5);
        check_reg("R3 start set", 3'd0, 32'h0000_8085);
        check_reg("R3 arg held", 3'd1, 32'h0000_00AA);
        answer(5'd4, {32'h0BAD_F00D, 96'h0});
        check_reg("R3 start clear", 3'd0, 32'h0000_0085);
        check_reg("R4 word0", 3'd4, 32'h0BAD_F00D);
    endtask

    task automatic t_norsp();
        run_cmd(16'h8400, 32'h0, 5'd0, '0);
        check_reg("R6 no fail", 3'd0, 32'h0000_0400);
        check_reg("R6 status", 3'd2, 32'h0);
        run_cmd(16'h8400, 32'h0, 5'd16, {128{1'b1}});
        check_reg("R6 words kept", 3'd4, 32'h0BAD_F00D);
    endtask

    task automatic t_fail(input logic [15:0] word, input logic [4:0] len);
        run_cmd(word, 32'h0, len, {128{1'b1}});
        check_reg("R7 fail bit", 3'd0, {16'h0, (word & 16'h7FFF) | 16'h4000});
        check_reg("R7 timeout", 3'd2, 32'h0000_0040);
        check_reg("R7 words kept", 3'd4, 32'h0BAD_F00D);
        check_reg("R7 words kept", 3'd5, 32'h0);
        wr(3'd2, 32'h0000_0040);
    endtask

    task automatic t_sticky();
        run_cmd(16'h8001, 32'h0, 5'd0, '0);
        wr(3'd2, 32'h0000_0400);
        check_reg("R8 timeout stays", 3'd2, 32'h0000_0040);
        wr(3'd0, 32'h0000_4001);
        check_reg("R8 fail cleared by write", 3'd0, 32'h0000_0001);
        check_reg("R8 timeout still", 3'd2, 32'h0000_0040);
        wr(3'd2, 32'h0000_0040);
        check_reg("R8 timeout cleared", 3'd2, 32'h0);
    endtask

    task automatic t_short_gets_long();
        run_cmd(16'h8008, 32'h0, 5'd16, LONG_DATA);
        check_reg("R11 no fail", 3'd0, 32'h0000_0008);
        for (int k = 0; k < 4; k++)
            check_reg("R11 word", 3'(4 + k), LONG_DATA[k*32 +: 32]);
    endtask

    task automatic t_busy_irq();
        run_cmd(16'h8800, 32'h0, 5'd4, '0);
        check("R9 irq off when disabled", {31'h0, irq}, 32'h0);
        wr(3'd3, 32'h0000_0400);
        check_reg("R9 cfg", 3'd3, 32'h0000_0400);
        run_cmd(16'h8800, 32'h0, 5'd0, '0);
        check("R9 no irq on fail", {31'h0, irq}, 32'h0);
        wr(3'd2, 32'h0000_0040);
        run_cmd(16'h8800, 32'h0, 5'd4, '0);
        check("R9 irq", {31'h0, irq}, 32'h1);
        check_reg("R9 status", 3'd2, 32'h0000_0400);
        wr(3'd2, 32'h0000_0400);
        check("R9 irq cleared", {31'h0, irq}, 32'h0);
        run_cmd(16'h8C00, 32'h0, 5'd0, '0);
        check("R9 irq no-response", {31'h0, irq}, 32'h1);
        wr(3'd2, 32'h0000_0400);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_only();
        t_long();
        t_short();
        t_outstanding();
        t_norsp();
        t_fail(16'h8001, 5'd0);
        t_fail(16'h8202, 5'd4);
        t_fail(16'h8003, 5'd7);
        t_sticky();
        t_short_gets_long();
        t_busy_irq();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule